// File: doc/BRIEF.md
# Multi-Mode Programmable Logic Cell

This block is one configurable logic cell of a fine-grained programmable fabric. It holds a 16-entry lookup table, a single state register with a synchronous clock enable, a carry path (one bit in, one bit out) and a cascade path (one bit in, one bit out). A static two-bit mode input picks how the table and the register are used. In the general mode the table is one 4-input function. In the adder mode it is split into two 3-input functions: one for the result and one for the carry. In the two counter modes the cell becomes one bit of a loadable counter. One of these counters counts up or down. The other counts up and has a synchronous clear.

The cell's function output is merged with the cascade input by AND or by OR, as a configuration bit selects. The merged value leaves on the cascade output. Two result pins, one local and one global, each choose on their own whether they carry the merged combinational value or the register. With register packing, the register stores an unrelated input while the table goes on serving the outputs. All configuration inputs are static in use. Reset is synchronous and active high.

Top module: `mlc_cell`

## Requirements
- R1: When `rst` is high at a rising clock edge, the register becomes 0 (the `RST_VAL` default), whatever `clk_en` and the other inputs are.
- R2: When `clk_en` is low and `rst` is low at an edge, the register keeps its value in every mode.
- R3: Mode 0 (general): the function value is `cfg_table[k]`, where k = `d1` + 2·s + 4·... that is, k = d1 + 2·d2 + 4·s + 8·d4, and s is `carry_in` when `cfg_cin_sel` is 1 and `d3` when it is 0. In this mode `carry_out` is 0.
- R4: `casc_out` equals the function value AND `casc_in` when `cfg_casc_or` is 0, and the function value OR `casc_in` when it is 1. So `casc_in` = 0 forces `casc_out` to 0 under AND, and `casc_in` = 1 forces it to 1 under OR.
- R5: Mode 1 (adder): with j = d1 + 2·d2 + 4·carry_in, the function value is `cfg_table[j]` and `carry_out` is `cfg_table[8 + j]`.
- R6: In modes 0 and 1, with `cfg_pack` = 0 in mode 0, an enabled edge loads `casc_out` into the register.
- R7: In mode 0 with `cfg_pack` = 1, an enabled edge loads `d4` into the register, while the outputs still show the table result.
- R8: `loc_out` shows the register when `cfg_loc_reg` is 1 and `casc_out` when it is 0. `glb_out` does the same, independently, under `cfg_glb_reg`.
- R9: Mode 2 (up/down counter) ignores `cfg_table`. With q the register, the function value is q XOR (`d1` AND `carry_in`). `carry_out` is q AND `carry_in` when `d2` is 1 (up), and NOT q AND `carry_in` when `d2` is 0 (down). An enabled edge loads the function value when `d4` is 1, and `d3` when `d4` is 0 (active-low load).
- R10: Mode 3 (clearable counter) ignores `cfg_table` and always counts up: the function value is q XOR (`d1` AND `carry_in`), and `carry_out` is q AND `carry_in`. An enabled edge loads (`d4` ? function value : `d3`) AND `d2`, so `d2` = 0 clears the register synchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 0 general, 1 adder, 2 up/down counter, 3 clearable counter |
| cfg_table | input | 16 | Lookup-table contents |
| cfg_cin_sel | input | 1 | General mode: table input 2 takes carry_in instead of d3 |
| cfg_casc_or | input | 1 | Cascade merge: 0 AND, 1 OR |
| cfg_pack | input | 1 | General mode: register loads d4 directly |
| cfg_loc_reg | input | 1 | loc_out shows register (1) or merged value (0) |
| cfg_glb_reg | input | 1 | glb_out shows register (1) or merged value (0) |
| clk_en | input | 1 | Synchronous register clock enable |
| d1 | input | 1 | Data input 1 (count enable in counter modes) |
| d2 | input | 1 | Data input 2 (direction, or active-low clear) |
| d3 | input | 1 | Data input 3 (load data in counter modes) |
| d4 | input | 1 | Data input 4 (active-low load in counter modes) |
| carry_in | input | 1 | Carry from the lower-order cell |
| casc_in | input | 1 | Cascade from the preceding cell |
| carry_out | output | 1 | Carry to the higher-order cell |
| casc_out | output | 1 | Merged function value and cascade output |
| loc_out | output | 1 | Local result |
| glb_out | output | 1 | Global result |

## Verification
The assertions assume that every input is a known value at each rising edge, and that reset is asserted at the first edge, so the register is defined before any check that reads its history. The configuration inputs are static in use. The properties only require them to be settled at each edge, because they compare the register against values sampled one edge earlier. The stimulus changes every input, configuration included, only at falling edges. It holds reset for the opening cycles, so the register is never read undefined.

// File: rtl/mlc_pkg.sv
package mlc_pkg;
  localparam int LUT_IN   = 4;
  localparam int LUT_BITS = 1 << LUT_IN;
  localparam int SUB_IN   = LUT_IN - 1;
  localparam int SUB_BITS = 1 << SUB_IN;

  typedef enum logic [1:0] {
    MODE_GENERAL = 2'd0,
    MODE_ADDER   = 2'd1,
    MODE_UPDN    = 2'd2,
    MODE_CLRCNT  = 2'd3
  } mlc_mode_e;

  // counter result table, select = {enable, carry_in, q}
  function automatic logic [SUB_BITS-1:0] cnt_sum_tbl();
    logic [SUB_BITS-1:0] t;
    logic [SUB_IN-1:0]   k;
    for (int i = 0; i < SUB_BITS; i++) begin
      k    = SUB_IN'(i);
      t[i] = k[0] ^ (k[1] & k[2]);
    end
    return t;
  endfunction

  // counter carry table, select = {up, carry_in, q}
  function automatic logic [SUB_BITS-1:0] cnt_carry_tbl();
    logic [SUB_BITS-1:0] t;
    logic [SUB_IN-1:0]   k;
    for (int i = 0; i < SUB_BITS; i++) begin
      k    = SUB_IN'(i);
      t[i] = k[2] ? (k[0] & k[1]) : (~k[0] & k[1]);
    end
    return t;
  endfunction
endpackage

// File: rtl/mlc_lut.sv
module mlc_lut #(
  parameter int IN_W = 4
) (
  input  logic [(1<<IN_W)-1:0] tbl,
  input  logic [IN_W-1:0]      sel,
  output logic                 y
);
  assign y = tbl[sel];
endmodule

// File: rtl/mlc_cascade.sv
module mlc_cascade (
  input  logic f,
  input  logic chain_in,
  input  logic use_or,
  output logic y
);
  // OR is formed as an inverted AND of inverted terms
  always_comb begin
    if (use_or) y = ~(~f & ~chain_in);
    else        y = f & chain_in;
  end
endmodule

// File: rtl/mlc_next.sv
module mlc_next
  import mlc_pkg::*;
(
  input  mlc_mode_e mode,
  input  logic      pack,
  input  logic      merged,
  input  logic      f,
  input  logic      d2,
  input  logic      d3,
  input  logic      d4,
  output logic      nxt
);
  logic loaded;
  assign loaded = d4 ? f : d3;

  always_comb begin
    unique case (mode)
      MODE_GENERAL: nxt = pack ? d4 : merged;
      MODE_ADDER:   nxt = merged;
      MODE_UPDN:    nxt = loaded;
      MODE_CLRCNT:  nxt = loaded & d2;
      default:      nxt = merged;
    endcase
  end
endmodule

// File: rtl/mlc_cell.sv
module mlc_cell
  import mlc_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          cfg_mode,
  input  logic [LUT_BITS-1:0] cfg_table,
  input  logic                cfg_cin_sel,
  input  logic                cfg_casc_or,
  input  logic                cfg_pack,
  input  logic                cfg_loc_reg,
  input  logic                cfg_glb_reg,
  input  logic                clk_en,
  input  logic                d1,
  input  logic                d2,
  input  logic                d3,
  input  logic                d4,
  input  logic                carry_in,
  input  logic                casc_in,
  output logic                carry_out,
  output logic                casc_out,
  output logic                loc_out,
  output logic                glb_out
);
  localparam logic [SUB_BITS-1:0] CNT_SUM   = cnt_sum_tbl();
  localparam logic [SUB_BITS-1:0] CNT_CARRY = cnt_carry_tbl();
  localparam int HALVES = 2;

  mlc_mode_e mode;
  assign mode = mlc_mode_e'(cfg_mode);

  logic q_r;
  logic f, merged, nxt, y4, up;
  logic [LUT_IN-1:0]   sel4;
  logic [SUB_BITS-1:0] sub_tbl [HALVES];
  logic [SUB_IN-1:0]   sub_sel [HALVES];
  logic                sub_y   [HALVES];

  // single 4-input table for the general mode
  assign sel4 = {d4, (cfg_cin_sel ? carry_in : d3), d2, d1};
  mlc_lut #(.IN_W(LUT_IN)) u_lut4 (.tbl(cfg_table), .sel(sel4), .y(y4));

  // split tables: half 0 gives the result, half 1 gives the carry
  assign up = (mode == MODE_CLRCNT) ? 1'b1 : d2;
  always_comb begin
    if (mode == MODE_ADDER) begin
      sub_tbl[0] = cfg_table[SUB_BITS-1:0];
      sub_tbl[1] = cfg_table[LUT_BITS-1:SUB_BITS];
      sub_sel[0] = {carry_in, d2, d1};
      sub_sel[1] = {carry_in, d2, d1};
    end else begin
      sub_tbl[0] = CNT_SUM;
      sub_tbl[1] = CNT_CARRY;
      sub_sel[0] = {d1, carry_in, q_r};
      sub_sel[1] = {up, carry_in, q_r};
    end
  end

  for (genvar g = 0; g < HALVES; g++) begin : g_half
    mlc_lut #(.IN_W(SUB_IN)) u_lut3 (
      .tbl(sub_tbl[g]), .sel(sub_sel[g]), .y(sub_y[g])
    );
  end

  assign f         = (mode == MODE_GENERAL) ? y4 : sub_y[0];
  assign carry_out = (mode == MODE_GENERAL) ? 1'b0 : sub_y[1];

  mlc_cascade u_casc (.f(f), .chain_in(casc_in), .use_or(cfg_casc_or), .y(merged));
  assign casc_out = merged;

  mlc_next u_next (
    .mode(mode), .pack(cfg_pack), .merged(merged), .f(f),
    .d2(d2), .d3(d3), .d4(d4), .nxt(nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)         q_r <= RST_VAL;
    else if (clk_en) q_r <= nxt;
  end

  assign loc_out = cfg_loc_reg ? q_r : merged;
  assign glb_out = cfg_glb_reg ? q_r : merged;
endmodule

// File: rtl/mlc_cell_chk.sv
module mlc_cell_chk #(
  parameter logic RST_VAL = 1'b0
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cfg_mode,
  input logic       cfg_casc_or,
  input logic       cfg_pack,
  input logic       clk_en,
  input logic       d2,
  input logic       d3,
  input logic       d4,
  input logic       casc_in,
  input logic       casc_out,
  input logic       carry_out,
  input logic       q
);
  assert_reset_value_R1: assert property (@(posedge clk)
    rst |=> (q == RST_VAL));

  assert_hold_no_enable_R2: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> $stable(q));

  assert_general_no_carry_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'd0) |-> !carry_out);

  assert_cascade_and_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_casc_or && !casc_in) |-> !casc_out);

  assert_cascade_or_one_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_casc_or && casc_in) |-> casc_out);

  assert_pack_loads_d4_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'd0 && cfg_pack && clk_en) |=> (q == $past(d4)));

  assert_updn_load_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'd2 && clk_en && !d4) |=> (q == $past(d3)));

  assert_sync_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'd3 && clk_en && !d2) |=> !q);
endmodule

bind mlc_cell mlc_cell_chk #(.RST_VAL(RST_VAL)) u_chk (
  .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_casc_or(cfg_casc_or),
  .cfg_pack(cfg_pack), .clk_en(clk_en), .d2(d2), .d3(d3), .d4(d4),
  .casc_in(casc_in), .casc_out(casc_out), .carry_out(carry_out), .q(q_r)
);

// File: tb/mlc_cell_test.sv
`timescale 1ns/1ps
module mlc_cell_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1;
  logic [1:0]  cfg_mode = '0;
  logic [15:0] cfg_table = '0;
  logic cfg_cin_sel = 0, cfg_casc_or = 0, cfg_pack = 0;
  logic cfg_loc_reg = 1, cfg_glb_reg = 0, clk_en = 0;
  logic d1 = 0, d2 = 0, d3 = 0, d4 = 0, carry_in = 0, casc_in = 1;
  logic carry_out, casc_out, loc_out, glb_out;

  mlc_cell uut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_table(cfg_table),
    .cfg_cin_sel(cfg_cin_sel), .cfg_casc_or(cfg_casc_or), .cfg_pack(cfg_pack),
    .cfg_loc_reg(cfg_loc_reg), .cfg_glb_reg(cfg_glb_reg), .clk_en(clk_en),
    .d1(d1), .d2(d2), .d3(d3), .d4(d4), .carry_in(carry_in), .casc_in(casc_in),
    .carry_out(carry_out), .casc_out(casc_out), .loc_out(loc_out), .glb_out(glb_out)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic mq;            // modelled register
  string qtag;         // requirement governing the last register update

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b (mode %0d)", tag, act, exp, cfg_mode);
    end
  endtask

  function automatic string mode_tag();
    case (cfg_mode)
      2'd0:    return "R3";
      2'd1:    return "R5";
      2'd2:    return "R9";
      default: return "R10";
    endcase
  endfunction

  // one cycle: drive at the falling edge, check, then let the rising edge act
  task automatic step();
    logic f, cy, mg, nq, exp_l, exp_g;
    logic [3:0] k4;
    logic [2:0] k3;
    #1;
    case (cfg_mode)
      2'd0: begin
        k4 = {d4, (cfg_cin_sel ? carry_in : d3), d2, d1};
        f = cfg_table[k4]; cy = 1'b0;
      end
      2'd1: begin
        k3 = {carry_in, d2, d1};
        f = cfg_table[k3]; cy = cfg_table[8 + k3];
      end
      2'd2: begin
        f = mq ^ (d1 & carry_in);
        cy = d2 ? (mq & carry_in) : (~mq & carry_in);
      end
      default: begin
        f = mq ^ (d1 & carry_in); cy = mq & carry_in;
      end
    endcase
    mg = cfg_casc_or ? (f | casc_in) : (f & casc_in);
    chk(mode_tag(), carry_out, cy);
    if (cfg_casc_or == casc_in) chk("R4", casc_out, mg);
    else                        chk(mode_tag(), casc_out, mg);
    exp_l = cfg_loc_reg ? mq : mg;
    exp_g = cfg_glb_reg ? mq : mg;
    chk(cfg_loc_reg ? qtag : "R8", loc_out, exp_l);
    chk(cfg_glb_reg ? qtag : "R8", glb_out, exp_g);
    // next register value
    if (rst) begin
      nq = 1'b0; qtag = "R1";
    end else if (!clk_en) begin
      nq = mq; qtag = "R2";
    end else begin
      case (cfg_mode)
        2'd0: begin nq = cfg_pack ? d4 : mg; qtag = cfg_pack ? "R7" : "R6"; end
        2'd1: begin nq = mg; qtag = "R6"; end
        2'd2: begin nq = d4 ? f : d3; qtag = "R9"; end
        default: begin nq = (d4 ? f : d3) & d2; qtag = "R10"; end
      endcase
    end
    @(posedge clk);
    mq = nq;
    @(negedge clk);
  endtask

  localparam logic [15:0] TABLES [4] = '{16'hA5C3, 16'h6996, 16'hE817, 16'h0F3C};

  initial begin
    // reset state: register visible on loc_out (R1)
    @(negedge clk);
    rst = 1; clk_en = 1; d4 = 1; cfg_loc_reg = 1; cfg_glb_reg = 1;
    @(posedge clk); @(negedge clk);
    chk("R1", loc_out, 1'b0);
    chk("R1", glb_out, 1'b0);
    mq = 1'b0; qtag = "R1";
    rst = 0;
    for (int m = 0; m < 4; m++) begin
      for (int t = 0; t < 4; t++) begin
        for (int v = 0; v < 512; v++) begin
          logic [8:0] b;
          b = 9'(v);
          cfg_mode    = 2'(m);
          cfg_table   = TABLES[t];
          d1 = b[0]; d2 = b[1]; d3 = b[2]; d4 = b[3];
          carry_in = b[4]; casc_in = b[5];
          clk_en = b[6] | b[7];
          cfg_casc_or = b[7];
          cfg_cin_sel = b[8];
          cfg_pack    = b[8] ^ b[1];
          cfg_loc_reg = b[2] ^ b[5] ^ t[0];
          cfg_glb_reg = b[3] ^ b[4];
          rst = (v == 100);
          step();
        end
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule